// File: doc/BRIEF.md
# Block-Acknowledged SPI Byte Buffer

This block sits between a 32-bit host data register and a byte-serial SPI shift engine. It holds two 16-byte rings, one per direction. The host moves data in blocks of up to 16 bytes, one 32-bit word per access. A word carries up to four bytes, with the earliest byte in the least significant lane.

On transmit, the host writes words and then pulses a done strobe. Only after that strobe may the engine pull those bytes. A request bit tells the host when the ring has drained far enough to take the next block. On receive, the engine pushes bytes one at a time. A request bit rises once a full block is waiting, or once the engine reports that no more bytes will arrive. The host reads words, pulses a done strobe, and the request bit drops.

Block size is set by two watermark inputs. Each one is the block size minus one, normally 15. The engine stalls on the empty and full flags. Bytes that the host offers without room are dropped, and a sticky overflow flag is set.

Top module: `spi_blk_buf`

## Requirements
- R1: While reset is applied and after release: `host_tx_req`=1, `eng_tx_empty`=1, `host_rx_req`=0, `eng_rx_full`=0, `host_tx_ovf`=0.
- R2: Transmit packing. A write of `host_tx_wdata` with `host_tx_len_m1`=k places k+1 bytes in the ring: bits [7:0] first, then [15:8], and so on. Lanes above k are discarded. The engine receives the bytes in host write order on `eng_tx_byte`, and each `eng_tx_pop` advances by one byte.
- R3: Written bytes are not visible to the engine until `host_tx_done` is pulsed. `eng_tx_empty` stays 1 before the strobe and is 0 in the cycle after it.
- R4: `host_tx_req` is 0 in the cycle after `host_tx_done`. It returns to 1 one cycle after the ring level falls to 15 minus `host_tx_wm` or below.
- R5: A host write whose byte count exceeds the free space is dropped completely. The ring contents are unchanged, and `host_tx_ovf` becomes 1 in the next cycle and stays 1 until reset.
- R6: Receive unpacking. `host_rx_rdata` shows the oldest held byte in bits [7:0], the next in [15:8], and so on. Lanes past the held byte count read as zero. A pulse of `host_rx_re` removes min(4, level) bytes.
- R7: `host_rx_req` rises one cycle after the receive level exceeds `host_rx_wm`.
- R8: A short final block raises `host_rx_req` one cycle after `eng_rx_remain` is 0 with at least one byte held.
- R9: `host_rx_req` is 0 in the cycle after `host_rx_done`. It rises again one cycle later if a block condition still holds.
- R10: `eng_rx_full` is 1 while 16 bytes are held. A push while full is dropped.
- R11: The watermarks are programmable. With `host_tx_wm`=7, `host_tx_req` returns at level 8. With `host_rx_wm`=3, a 4-byte block raises `host_rx_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_tx_we | input | 1 | Host writes one transmit word |
| host_tx_wdata | input | 32 | Transmit word, earliest byte in the low lane |
| host_tx_len_m1 | input | 2 | Valid byte count of the word minus one |
| host_tx_done | input | 1 | Host marks the transmit block complete |
| host_tx_wm | input | 4 | Transmit watermark (block size minus one) |
| host_tx_req | output | 1 | Room for the next transmit block |
| host_tx_ovf | output | 1 | Sticky: a host write was dropped |
| host_rx_re | input | 1 | Host consumes the receive word shown |
| host_rx_rdata | output | 32 | Next receive word, unused lanes zero |
| host_rx_done | input | 1 | Host acknowledges the receive block |
| host_rx_wm | input | 4 | Receive watermark (block size minus one) |
| host_rx_req | output | 1 | A receive block is ready |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Next committed transmit byte |
| eng_tx_empty | output | 1 | No committed transmit byte is held |
| eng_rx_push | input | 1 | Engine delivers one receive byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive ring holds 16 bytes |
| eng_rx_remain | input | 16 | Bytes the engine has yet to deliver in this transfer |

## Verification
Ring levels, the commit count and the overflow flag change at the edge that takes the stimulus. Empty, full and both read views are combinational from those registers, so they can be checked right after that edge. The two request bits are computed from the registered level, which puts them one further edge late: R4, R7 and R8 are due two edges after the pop or push that crosses the threshold, and R4 and R9 are due one edge after a done strobe. The bench drives every input just after a rising edge, samples just after the next one, and adds exactly one idle cycle before each request-bit check.

// File: rtl/spi_blk_pkg.sv
package spi_blk_pkg;
  localparam int BYTE_W = 8;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/spi_blk_ring.sv
// Circular byte store, power-of-two depth. Up to WR_LANES bytes are
// written and up to RD_LANES bytes retired per cycle; the read side is a
// combinational peek at the oldest RD_LANES entries.
module spi_blk_ring
  import spi_blk_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int WR_LANES = 4,
  parameter int RD_LANES = 1,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int LVL_W   = $clog2(DEPTH + 1),
  localparam int WRC_W   = $clog2(WR_LANES + 1),
  localparam int RDC_W   = $clog2(RD_LANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WRC_W-1:0]             wr_cnt,
  input  logic [WR_LANES*BYTE_W-1:0]   wr_bytes,
  input  logic [RDC_W-1:0]             rd_cnt,
  output logic [RD_LANES*BYTE_W-1:0]   rd_bytes,
  output logic [LVL_W-1:0]             level
);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, wr_ptr_nxt;
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_nxt;
  logic [LVL_W-1:0]  level_nxt;
  logic              ring_en;

  // next state
  always_comb begin
    ring_en    = (wr_cnt != '0) || (rd_cnt != '0);
    wr_ptr_nxt = wr_ptr + PTR_W'(wr_cnt);
    rd_ptr_nxt = rd_ptr + PTR_W'(rd_cnt);
    level_nxt  = level + LVL_W'(wr_cnt) - LVL_W'(rd_cnt);
  end

  // peek
  always_comb begin
    for (int i = 0; i < RD_LANES; i++) begin
      rd_bytes[i*BYTE_W +: BYTE_W] = mem[rd_ptr + PTR_W'(i)];
    end
  end

  // storage, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < WR_LANES; i++) begin
      if (i < int'(wr_cnt)) begin
        mem[wr_ptr + PTR_W'(i)] <= wr_bytes[i*BYTE_W +: BYTE_W];
      end
    end
  end

  // pointer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (ring_en) begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      level  <= level_nxt;
    end
  end

  // R5 / R10: control never writes past free space or reads past held data
  a_r5_ring_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) + int'(wr_cnt) - int'(rd_cnt)) <= DEPTH);
  a_r10_ring_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_cnt) <= int'(level));

endmodule

// File: rtl/spi_blk_tx.sv
// Transmit side: host word writes, block commit on done, engine byte pops.
module spi_blk_tx
  import spi_blk_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int LEN_W = $clog2(LANES),
  localparam int WRC_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [LANES*BYTE_W-1:0] wr_word,
  input  logic [LEN_W-1:0]        wr_len_m1,
  input  logic                    done,
  input  logic [PTR_W-1:0]        wm,
  input  logic                    pop,
  output logic [BYTE_W-1:0]       byte_o,
  output logic                    empty,
  output logic                    req,
  output logic                    ovf
);

  logic [LVL_W-1:0] level;
  logic [LVL_W-1:0] pend, pend_nxt;     // written but not yet committed
  logic [LVL_W-1:0] free_bytes;
  logic [LVL_W-1:0] avail;
  logic [LVL_W-1:0] thresh;
  logic [WRC_W-1:0] want;
  logic [WRC_W-1:0] wr_cnt;
  logic [0:0]       rd_cnt;
  logic             accept;
  logic             pend_en;
  logic             req_nxt, ovf_nxt;

  always_comb begin
    want       = WRC_W'(wr_len_m1) + WRC_W'(1);
    free_bytes = LVL_W'(DEPTH) - level;
    accept     = wr_en && (LVL_W'(want) <= free_bytes);
    wr_cnt     = accept ? want : '0;
    avail      = level - pend;
    empty      = (avail == '0);
    rd_cnt     = pop && !empty;
    thresh     = LVL_W'(DEPTH - 1) - LVL_W'(wm);
    pend_en    = done || accept;
    pend_nxt   = done ? '0 : (pend + LVL_W'(wr_cnt));
    req_nxt    = done ? 1'b0 : (req || (level <= thresh));
    ovf_nxt    = ovf || (wr_en && !accept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      req  <= 1'b1;
      ovf  <= 1'b0;
    end else begin
      if (pend_en) pend <= pend_nxt;
      req <= req_nxt;
      ovf <= ovf_nxt;
    end
  end

  spi_blk_ring #(
    .DEPTH    (DEPTH),
    .WR_LANES (LANES),
    .RD_LANES (1)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cnt   (wr_cnt),
    .wr_bytes (wr_word),
    .rd_cnt   (rd_cnt),
    .rd_bytes (byte_o),
    .level    (level)
  );

  a_r3_pend_within_level: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= level);
  a_r4_req_drops_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !req);
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

endmodule

// File: rtl/spi_blk_rx.sv
// Receive side: engine byte pushes, host word reads, block request/ack.
module spi_blk_rx
  import spi_blk_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int REM_W  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int RDC_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [BYTE_W-1:0]       byte_i,
  output logic                    full,
  input  logic [REM_W-1:0]        remain,
  input  logic                    rd_en,
  output logic [LANES*BYTE_W-1:0] rd_word,
  input  logic                    done,
  input  logic [PTR_W-1:0]        wm,
  output logic                    req
);

  logic [LVL_W-1:0]          level;
  logic [0:0]                wr_cnt;
  logic [RDC_W-1:0]          rd_cnt;
  logic [LANES*BYTE_W-1:0]   peek;
  logic                      ready;
  logic                      req_nxt;

  always_comb begin
    full    = (level == LVL_W'(DEPTH));
    wr_cnt  = push && !full;
    if (!rd_en)                       rd_cnt = '0;
    else if (level >= LVL_W'(LANES))  rd_cnt = RDC_W'(LANES);
    else                              rd_cnt = RDC_W'(level);
    for (int i = 0; i < LANES; i++) begin
      rd_word[i*BYTE_W +: BYTE_W] = (LVL_W'(i) < level) ? peek[i*BYTE_W +: BYTE_W] : '0;
    end
    ready   = (level > LVL_W'(wm)) || ((remain == '0) && (level != '0));
    req_nxt = done ? 1'b0 : (req || ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_nxt;
  end

  spi_blk_ring #(
    .DEPTH    (DEPTH),
    .WR_LANES (1),
    .RD_LANES (LANES)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cnt   (wr_cnt),
    .wr_bytes (byte_i),
    .rd_cnt   (rd_cnt),
    .rd_bytes (peek),
    .level    (level)
  );

  a_r9_req_drops_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !req);
  a_r10_full_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);

endmodule

// File: rtl/spi_blk_buf.sv
module spi_blk_buf
  import spi_blk_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int REM_W  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(LANES),
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_tx_we,
  input  logic [WORD_W-1:0] host_tx_wdata,
  input  logic [LEN_W-1:0]  host_tx_len_m1,
  input  logic              host_tx_done,
  input  logic [PTR_W-1:0]  host_tx_wm,
  output logic              host_tx_req,
  output logic              host_tx_ovf,
  input  logic              host_rx_re,
  output logic [WORD_W-1:0] host_rx_rdata,
  input  logic              host_rx_done,
  input  logic [PTR_W-1:0]  host_rx_wm,
  output logic              host_rx_req,
  input  logic              eng_tx_pop,
  output logic [BYTE_W-1:0] eng_tx_byte,
  output logic              eng_tx_empty,
  input  logic              eng_rx_push,
  input  logic [BYTE_W-1:0] eng_rx_byte,
  output logic              eng_rx_full,
  input  logic [REM_W-1:0]  eng_rx_remain
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  spi_blk_tx #(
    .DEPTH (DEPTH),
    .LANES (LANES)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (host_tx_we),
    .wr_word   (host_tx_wdata),
    .wr_len_m1 (host_tx_len_m1),
    .done      (host_tx_done),
    .wm        (host_tx_wm),
    .pop       (eng_tx_pop),
    .byte_o    (eng_tx_byte),
    .empty     (eng_tx_empty),
    .req       (host_tx_req),
    .ovf       (host_tx_ovf)
  );

  spi_blk_rx #(
    .DEPTH (DEPTH),
    .LANES (LANES),
    .REM_W (REM_W)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push    (eng_rx_push),
    .byte_i  (eng_rx_byte),
    .full    (eng_rx_full),
    .remain  (eng_rx_remain),
    .rd_en   (host_rx_re),
    .rd_word (host_rx_rdata),
    .done    (host_rx_done),
    .wm      (host_rx_wm),
    .req     (host_rx_req)
  );

endmodule

// File: tb/tb_spi_blk_buf.sv
`timescale 1ns/1ps
module tb_spi_blk_buf;
  logic        clk;
  logic        rst_n;
  logic        host_tx_we;
  logic [31:0] host_tx_wdata;
  logic [1:0]  host_tx_len_m1;
  logic        host_tx_done;
  logic [3:0]  host_tx_wm;
  logic        host_tx_req;
  logic        host_tx_ovf;
  logic        host_rx_re;
  logic [31:0] host_rx_rdata;
  logic        host_rx_done;
  logic [3:0]  host_rx_wm;
  logic        host_rx_req;
  logic        eng_tx_pop;
  logic [7:0]  eng_tx_byte;
  logic        eng_tx_empty;
  logic        eng_rx_push;
  logic [7:0]  eng_rx_byte;
  logic        eng_rx_full;
  logic [15:0] eng_rx_remain;

  int tests = 0;
  int errs  = 0;
  bit finished = 0;

  spi_blk_buf dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_pat(input int seed, input int idx);
    return 8'((seed * 17) + (idx * 5) + 3);
  endfunction

  function automatic logic [7:0] rx_pat(input int seed, input int idx);
    return 8'((seed * 29) + (idx * 11) + 1);
  endfunction

  task automatic host_write(input logic [31:0] w, input int nbytes);
    host_tx_we = 1'b1;
    host_tx_wdata = w;
    host_tx_len_m1 = 2'(nbytes - 1);
    tick();
    host_tx_we = 1'b0;
  endtask

  // write bytes [from, from+len) of pattern seed as packed words
  task automatic tx_load(input int seed, input int from, input int len);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] word;
      int n;
      n = ((len - 4 * w) > 4) ? 4 : (len - 4 * w);
      word = 32'hEEEE_EEEE;
      for (int j = 0; j < n; j++) word[j*8 +: 8] = tx_pat(seed, from + 4 * w + j);
      host_write(word, n);
    end
  endtask

  task automatic tx_commit();
    host_tx_done = 1'b1;
    tick();
    host_tx_done = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [7:0] exp);
    chk(req, {24'h0, eng_tx_byte}, {24'h0, exp});
    eng_tx_pop = 1'b1;
    tick();
    eng_tx_pop = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    eng_rx_push = 1'b1;
    eng_rx_byte = b;
    tick();
    eng_rx_push = 1'b0;
  endtask

  task automatic rx_read_check(input string req, input int seed, input int idx, input int lvl);
    logic [31:0] exp;
    exp = '0;
    for (int j = 0; j < 4; j++) if (j < lvl) exp[j*8 +: 8] = rx_pat(seed, idx + j);
    chk(req, host_rx_rdata, exp);
    host_rx_re = 1'b1;
    tick();
    host_rx_re = 1'b0;
  endtask

  task automatic rx_ack();
    host_rx_done = 1'b1;
    tick();
    host_rx_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      tests++;
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    host_tx_we = 0; host_tx_wdata = '0; host_tx_len_m1 = '0; host_tx_done = 0;
    host_tx_wm = 4'd15; host_rx_wm = 4'd15;
    host_rx_re = 0; host_rx_done = 0;
    eng_tx_pop = 0; eng_rx_push = 0; eng_rx_byte = '0; eng_rx_remain = 16'd100;
    repeat (3) tick();
    // R1 during reset
    chk("R1", {27'h0, host_tx_req, eng_tx_empty, host_rx_req, eng_rx_full, host_tx_ovf},
        32'b11000);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1", {27'h0, host_tx_req, eng_tx_empty, host_rx_req, eng_rx_full, host_tx_ovf},
        32'b11000);

    // R2 / R3 / R4: every block length, partial final word
    for (int len = 1; len <= 16; len++) begin
      tx_load(len, 0, len);
      chk("R3", {31'h0, eng_tx_empty}, 32'd1);
      tx_commit();
      chk("R3", {31'h0, eng_tx_empty}, 32'd0);
      chk("R4", {31'h0, host_tx_req}, 32'd0);
      for (int b = 0; b < len; b++) pop_check("R2", tx_pat(len, b));
      chk("R2", {31'h0, eng_tx_empty}, 32'd1);
      tick();
      chk("R4", {31'h0, host_tx_req}, 32'd1);
    end

    // R5: write into a full ring is dropped and flagged
    tx_load(40, 0, 16);
    tx_commit();
    chk("R5", {31'h0, host_tx_ovf}, 32'd0);
    host_write(32'hDEAD_BEEF, 4);
    chk("R5", {31'h0, host_tx_ovf}, 32'd1);
    for (int b = 0; b < 16; b++) pop_check("R5", tx_pat(40, b));
    chk("R5", {31'h0, eng_tx_empty}, 32'd1);
    tick();
    // R5: partial room, four-byte word dropped, two-byte word accepted
    tx_load(41, 0, 14);
    host_write(32'h1234_5678, 4);
    tx_load(41, 14, 2);
    tx_commit();
    for (int b = 0; b < 16; b++) pop_check("R5", tx_pat(41, b));
    chk("R5", {31'h0, host_tx_ovf}, 32'd1);
    tick();

    // R11: transmit watermark 7
    host_tx_wm = 4'd7;
    tx_load(42, 0, 16);
    tx_commit();
    for (int b = 0; b < 7; b++) pop_check("R11", tx_pat(42, b));
    tick();
    chk("R11", {31'h0, host_tx_req}, 32'd0);
    pop_check("R11", tx_pat(42, 7));
    tick();
    chk("R11", {31'h0, host_tx_req}, 32'd1);
    for (int b = 8; b < 16; b++) pop_check("R11", tx_pat(42, b));
    host_tx_wm = 4'd15;
    tick();

    // R7 / R10 / R6 / R9: full receive block
    for (int b = 0; b < 15; b++) rx_push(rx_pat(5, b));
    tick();
    chk("R7", {31'h0, host_rx_req}, 32'd0);
    chk("R10", {31'h0, eng_rx_full}, 32'd0);
    rx_push(rx_pat(5, 15));
    chk("R10", {31'h0, eng_rx_full}, 32'd1);
    rx_push(8'hA5);
    chk("R7", {31'h0, host_rx_req}, 32'd1);
    rx_read_check("R6", 5, 0, 16);
    chk("R10", {31'h0, eng_rx_full}, 32'd0);
    for (int w = 1; w < 4; w++) rx_read_check("R6", 5, 4 * w, 16 - 4 * w);
    chk("R10", host_rx_rdata, 32'h0);
    rx_ack();
    chk("R9", {31'h0, host_rx_req}, 32'd0);

    // R8 / R6: short final blocks of every length
    for (int len = 1; len <= 15; len++) begin
      eng_rx_remain = 16'(len);
      for (int b = 0; b < len - 1; b++) begin
        rx_push(rx_pat(len, b));
        eng_rx_remain = 16'(len - b - 1);
      end
      rx_push(rx_pat(len, len - 1));
      chk("R8", {31'h0, host_rx_req}, 32'd0);
      eng_rx_remain = 16'd0;
      tick();
      chk("R8", {31'h0, host_rx_req}, 32'd1);
      for (int w = 0; w < (len + 3) / 4; w++) rx_read_check("R6", len, 4 * w, len - 4 * w);
      rx_ack();
      chk("R9", {31'h0, host_rx_req}, 32'd0);
      tick();
      chk("R8", {31'h0, host_rx_req}, 32'd0);
    end

    // R9: acknowledge with data left re-raises the request
    eng_rx_remain = 16'd0;
    for (int b = 0; b < 6; b++) rx_push(rx_pat(9, b));
    tick();
    chk("R9", {31'h0, host_rx_req}, 32'd1);
    rx_read_check("R6", 9, 0, 6);
    rx_ack();
    chk("R9", {31'h0, host_rx_req}, 32'd0);
    tick();
    chk("R9", {31'h0, host_rx_req}, 32'd1);
    rx_read_check("R6", 9, 4, 2);
    rx_ack();
    chk("R9", {31'h0, host_rx_req}, 32'd0);
    eng_rx_remain = 16'd100;
    tick();

    // R11: receive watermark 3
    host_rx_wm = 4'd3;
    for (int b = 0; b < 3; b++) rx_push(rx_pat(12, b));
    tick();
    chk("R11", {31'h0, host_rx_req}, 32'd0);
    rx_push(rx_pat(12, 3));
    tick();
    chk("R11", {31'h0, host_rx_req}, 32'd1);
    rx_read_check("R11", 12, 0, 4);
    rx_ack();
    chk("R11", {31'h0, host_rx_req}, 32'd0);
    host_rx_wm = 4'd15;
    tick();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, errs);
    $finish;
  end
endmodule